// File: doc/BRIEF.md
# Serial Register Access Port

This block is the two-wire serial slave front end of a small timekeeping core. A bus master reaches the core's sixteen byte-wide locations through it. SCL and the SDA line level are sampled on a fast system clock. The block answers one fixed 7-bit device address, 1010001b. The first bus byte is A2h for a write and A3h for a read. On the core side it offers a plain synchronous register-file port: an address, write data, a one-cycle write enable, and read data that the core returns for the presented address.

A write transfer carries a word address byte, which sets an internal 4-bit pointer. Any further bytes go to successive locations. A read transfer streams bytes starting at whatever the pointer holds, so a master first sends a write with only the word address and then starts a read. The pointer moves on by one after every byte, in both directions, and wraps from 0Fh to 00h. SDA is driven only low, as an open-drain line.

The dedicated reset input clears only the serial engine and the pointer. Nothing in it can alter the contents of the core's registers.

Top module: `regAccessPort`

## Requirements
- R1: The address byte A2h (device address 1010001b, bit 0 = 0) starts a write transfer and A3h (bit 0 = 1) starts a read transfer. Both are acknowledged.
- R2: An address byte whose upper seven bits differ from 1010001b is not acknowledged. The block then drives nothing and writes nothing until the next START.
- R3: In a write transfer, the first byte after the address loads its low four bits into the pointer. Its upper four bits are ignored.
- R4: Each later byte of a write transfer produces one single-cycle regWe pulse, with regAddr equal to the pointer and regWData equal to the byte (sent MSB first). The pointer then advances by one.
- R5: A read transfer returns, MSB first, the byte at the current pointer and then the following locations. The pointer advances by one for every byte sent.
- R6: The pointer wraps from 0Fh to 00h on both writes and reads.
- R7: Every byte the block accepts (matching address, word address, data) is acknowledged by holding SDA low for the ninth clock.
- R8: When the master does not acknowledge a read byte, the block releases SDA and sends nothing more until the next START.
- R9: A STOP seen mid-byte returns the block to idle. A START seen mid-byte begins a new address byte. A partial byte is never written.
- R10: busRstN low clears the pointer to 0 and releases SDA. It issues no register write, so the core's contents stay as they were.
- R11: sdaLow changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| busRstN | input | 1 | Active-low asynchronous reset of the serial engine and pointer |
| sclPin | input | 1 | Bus clock level |
| sdaPin | input | 1 | Bus data line level |
| sdaLow | output | 1 | Pulls the data line low when 1 (open drain) |
| regAddr | output | 4 | Location addressed in the core (the pointer) |
| regWData | output | 8 | Byte to write into the core |
| regWe | output | 1 | One-cycle write strobe to the core |
| regRData | input | 8 | Byte the core returns for regAddr |

## Verification
Bursts are written and read at a mid-range pointer, across the 0Fh boundary, and with a word address byte whose upper nibble is set. These runs separate a correct pointer advance and wrap from a stuck, unwrapped or over-wide pointer. Foreign address bytes and a read closed by a master NACK, followed by more clocking, show whether the block stays off the line. STOP and START placed inside a byte, and a bus reset between transfers, show whether partial bytes leak into the core and whether only the pointer is cleared.

// File: rtl/regAccessPkg.sv
`timescale 1ns/1ps
package regAccessPkg;
  // Strobes issued by the control to the datapath, one cycle each
  typedef struct packed {
    logic captureBit;  // shift the sampled SDA bit in
    logic loadPtr;     // pointer takes the received word address
    logic incPtr;      // pointer advances by one
    logic writeByte;   // hand received byte to the core
    logic ackDrive;    // pull SDA low for the acknowledge clock
    logic loadTx;      // fetch a byte from the core and drive its MSB
    logic nextTx;      // move to the next transmit bit
    logic releaseSda;  // let SDA float
  } portStrobesT;
endpackage

// File: rtl/regAccessCtrl.sv
`timescale 1ns/1ps
module regAccessCtrl
  import regAccessPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-2:0] DEV_ADDR = 7'h51
) (
  input  logic              clk,
  input  logic              busRstN,
  input  logic              sclPin,
  input  logic              sdaPin,
  input  logic [BYTE_W-1:0] rxByte,
  output portStrobesT       strb,
  output logic              sdaBit
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEVADDR, ST_DEVACK, ST_WORD, ST_WORDACK,
    ST_WDATA, ST_WDATAACK, ST_RDATA, ST_RACK
  } portStateT;

  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclS, sdaS, sclRise, sclFall, startSeen, stopSeen;
  portStateT state, stateNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic readMode, readNext, masterAck, mAckNext;

  always_ff @(posedge clk or negedge busRstN) begin
    if (!busRstN) begin
      sclSync <= '1; sdaSync <= '1; sclPrev <= 1'b1; sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclPin};
      sdaSync <= {sdaSync[0], sdaPin};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclS      = sclSync[1];
  assign sdaS      = sdaSync[1];
  assign sdaBit    = sdaS;
  assign sclRise   = sclS & ~sclPrev;
  assign sclFall   = ~sclS & sclPrev;
  assign startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_comb begin
    strb = '0; stateNext = state; cntNext = bitCnt;
    readNext = readMode; mAckNext = masterAck;
    if (startSeen) begin
      stateNext = ST_DEVADDR; cntNext = '0; strb.releaseSda = 1'b1;
    end else if (stopSeen) begin
      stateNext = ST_IDLE; cntNext = '0; strb.releaseSda = 1'b1;
    end else begin
      case (state)
        ST_DEVADDR, ST_WORD, ST_WDATA: begin
          if (sclRise && bitCnt != FULL) begin
            strb.captureBit = 1'b1;
            cntNext = bitCnt + CNT_W'(1);
          end else if (sclFall && bitCnt == FULL) begin
            cntNext = '0;
            if (state == ST_DEVADDR) begin
              if (rxByte[BYTE_W-1:1] == DEV_ADDR) begin
                strb.ackDrive = 1'b1; readNext = rxByte[0]; stateNext = ST_DEVACK;
              end else begin
                stateNext = ST_IDLE;
              end
            end else if (state == ST_WORD) begin
              strb.loadPtr = 1'b1; strb.ackDrive = 1'b1; stateNext = ST_WORDACK;
            end else begin
              strb.writeByte = 1'b1; strb.ackDrive = 1'b1; stateNext = ST_WDATAACK;
            end
          end
        end
        ST_DEVACK: if (sclFall) begin
          if (readMode) begin strb.loadTx = 1'b1; stateNext = ST_RDATA; end
          else begin strb.releaseSda = 1'b1; stateNext = ST_WORD; end
        end
        ST_WORDACK: if (sclFall) begin
          strb.releaseSda = 1'b1; stateNext = ST_WDATA;
        end
        ST_WDATAACK: if (sclFall) begin
          strb.releaseSda = 1'b1; strb.incPtr = 1'b1; stateNext = ST_WDATA;
        end
        ST_RDATA: begin
          if (sclRise) cntNext = bitCnt + CNT_W'(1);
          else if (sclFall) begin
            if (bitCnt == FULL) begin
              strb.releaseSda = 1'b1; strb.incPtr = 1'b1;
              cntNext = '0; stateNext = ST_RACK;
            end else begin
              strb.nextTx = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) mAckNext = ~sdaS;
          else if (sclFall) begin
            if (masterAck) begin strb.loadTx = 1'b1; stateNext = ST_RDATA; end
            else begin strb.releaseSda = 1'b1; stateNext = ST_IDLE; end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge busRstN) begin
    if (!busRstN) begin
      state <= ST_IDLE; bitCnt <= '0; readMode <= 1'b0; masterAck <= 1'b0;
    end else begin
      state <= stateNext; bitCnt <= cntNext;
      readMode <= readNext; masterAck <= mAckNext;
    end
  end

  // R9: STOP always lands in idle, START always opens a fresh address byte
  assert_stop_idles_R9: assert property (@(posedge clk) disable iff (!busRstN)
    stopSeen |=> state == ST_IDLE);
  assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!busRstN)
    startSeen |=> (state == ST_DEVADDR && bitCnt == '0));
  // R11: the line is only pulled while the synchronised clock is low
  assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!busRstN)
    (strb.ackDrive || strb.loadTx || strb.nextTx) |-> !sclS);
  // R2: a foreign address never reaches an acknowledge state
  assert_foreign_silent_R2: assert property (@(posedge clk) disable iff (!busRstN)
    (state == ST_IDLE) |=> (state == ST_IDLE || state == ST_DEVADDR));
endmodule

// File: rtl/regAccessData.sv
`timescale 1ns/1ps
module regAccessData
  import regAccessPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              busRstN,
  input  portStrobesT       strb,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] regRData,
  output logic [BYTE_W-1:0] rxByte,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWData,
  output logic              regWe,
  output logic              sdaLow
);
  logic [BYTE_W-1:0] shiftReg;
  logic [ADDR_W-1:0] ptr;
  logic              sdaOe;

  always_ff @(posedge clk or negedge busRstN) begin
    if (!busRstN) begin
      shiftReg <= '0; ptr <= '0; sdaOe <= 1'b0;
    end else begin
      if (strb.captureBit)  shiftReg <= {shiftReg[BYTE_W-2:0], sdaBit};
      else if (strb.loadTx) shiftReg <= regRData;
      else if (strb.nextTx) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b0};

      if (strb.loadPtr)     ptr <= shiftReg[ADDR_W-1:0];
      else if (strb.incPtr) ptr <= ptr + ADDR_W'(1);

      if (strb.ackDrive)        sdaOe <= 1'b1;
      else if (strb.loadTx)     sdaOe <= ~regRData[BYTE_W-1];
      else if (strb.nextTx)     sdaOe <= ~shiftReg[BYTE_W-2];
      else if (strb.releaseSda) sdaOe <= 1'b0;
    end
  end

  assign rxByte   = shiftReg;
  assign regAddr  = ptr;
  assign regWData = shiftReg;
  assign regWe    = strb.writeByte;
  assign sdaLow   = sdaOe;

  // R4: one strobe per byte, never two in a row
  assert_single_write_R4: assert property (@(posedge clk) disable iff (!busRstN)
    regWe |=> !regWe);
  // R6: every advance is +1 modulo the space, so 0Fh is followed by 00h
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!busRstN)
    strb.incPtr |=> ptr == $past(ptr) + ADDR_W'(1));
  // R10: reset leaves the line released and the pointer at zero
  assert_reset_clear_R10: assert property (@(posedge clk)
    !busRstN |-> (ptr == '0 && !sdaOe));
endmodule

// File: rtl/regAccessPort.sv
`timescale 1ns/1ps
module regAccessPort
  import regAccessPkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 4,
  parameter logic [BYTE_W-2:0] DEV_ADDR = 7'h51
) (
  input  logic              clk,
  input  logic              busRstN,
  input  logic              sclPin,
  input  logic              sdaPin,
  output logic              sdaLow,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWData,
  output logic              regWe,
  input  logic [BYTE_W-1:0] regRData
);
  portStrobesT       strb;
  logic              sdaBit;
  logic [BYTE_W-1:0] rxByte;

  regAccessCtrl #(.BYTE_W(BYTE_W), .DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk(clk), .busRstN(busRstN), .sclPin(sclPin), .sdaPin(sdaPin),
    .rxByte(rxByte), .strb(strb), .sdaBit(sdaBit)
  );

  regAccessData #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .busRstN(busRstN), .strb(strb), .sdaBit(sdaBit),
    .regRData(regRData), .rxByte(rxByte), .regAddr(regAddr),
    .regWData(regWData), .regWe(regWe), .sdaLow(sdaLow)
  );
endmodule

// File: tb/regAccessPort_bench.sv
`timescale 1ns/1ps
module regAccessPort_bench;
  localparam int Q = 48;  // quarter bus period, a multiple of the 8 ns clock

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic busRstN = 1'b0;
  logic sclPin = 1'b1;
  logic mSda = 1'b1;
  logic memPreset = 1'b1;
  logic sdaLow, regWe;
  logic [3:0] regAddr;
  logic [7:0] regWData, regRData;
  wire sdaLine = mSda & ~sdaLow;

  int checks = 0, fails = 0;
  int writeCount = 0, lowCount = 0, sclHighChanges = 0;
  logic prevLow = 1'b0;
  logic [7:0] mem [16];

  regAccessPort u_regAccessPort (
    .clk(clk), .busRstN(busRstN), .sclPin(sclPin), .sdaPin(sdaLine),
    .sdaLow(sdaLow), .regAddr(regAddr), .regWData(regWData),
    .regWe(regWe), .regRData(regRData)
  );

  // Core model: 16 bytes, combinational read
  assign regRData = mem[regAddr];
  always @(posedge clk) begin
    if (memPreset) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'h40 + 8'(i);
    end else if (regWe) begin
      mem[regAddr] <= regWData;
      writeCount <= writeCount + 1;
    end
    if (sdaLow) lowCount <= lowCount + 1;
    if (sdaLow != prevLow && sclPin) sclHighChanges <= sclHighChanges + 1;
    prevLow <= sdaLow;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic mStart();
    mSda = 1'b1; #(Q); sclPin = 1'b1; #(Q); mSda = 1'b0; #(Q); sclPin = 1'b0; #(Q);
  endtask
  task automatic mStop();
    mSda = 1'b0; #(Q); sclPin = 1'b1; #(Q); mSda = 1'b1; #(Q);
  endtask
  task automatic mBit(input bit b);
    mSda = b; #(Q); sclPin = 1'b1; #(2*Q); sclPin = 1'b0; #(Q);
  endtask
  task automatic mSendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) mBit(b[i]);
    mSda = 1'b1; #(Q); sclPin = 1'b1; #(Q); acked = !sdaLine; #(Q); sclPin = 1'b0; #(Q);
  endtask
  task automatic mReadByte(input bit giveAck, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #(Q); sclPin = 1'b1; #(Q); b[i] = sdaLine; #(Q); sclPin = 1'b0;
    end
    mSda = !giveAck; #(Q); sclPin = 1'b1; #(2*Q); sclPin = 1'b0; #(Q);
  endtask
  task automatic setPointer(input logic [7:0] w);
    bit a;
    mStart(); mSendByte(8'hA2, a); mSendByte(w, a); mStop();
  endtask

  task automatic testReset();
    check(sdaLow == 1'b0, "R10", "sdaLow after reset", sdaLow, 0);
    check(regAddr == 4'h0, "R10", "pointer after reset", regAddr, 0);
    check(regWe == 1'b0, "R10", "regWe after reset", regWe, 0);
  endtask

  task automatic testWriteBurst();
    bit a; int w0 = writeCount;
    mStart();
    mSendByte(8'hA2, a); check(a, "R1", "A2 acknowledged", a, 1);
    mSendByte(8'h03, a); check(a, "R7", "word address acknowledged", a, 1);
    mSendByte(8'h11, a); check(a, "R7", "data byte acknowledged", a, 1);
    mSendByte(8'h22, a);
    mSendByte(8'h33, a);
    mStop();
    check(mem[3] == 8'h11, "R4", "mem[3]", mem[3], 8'h11);
    check(mem[4] == 8'h22, "R4", "mem[4]", mem[4], 8'h22);
    check(mem[5] == 8'h33, "R4", "mem[5]", mem[5], 8'h33);
    check(writeCount - w0 == 3, "R4", "write strobes", writeCount - w0, 3);
    check(regAddr == 4'h6, "R4", "pointer after burst", regAddr, 6);
  endtask

  task automatic testReadBurst();
    bit a; logic [7:0] b;
    setPointer(8'h04);
    mStart();
    mSendByte(8'hA3, a); check(a, "R1", "A3 acknowledged", a, 1);
    mReadByte(1'b1, b); check(b == 8'h22, "R5", "read byte 0", b, 8'h22);
    mReadByte(1'b1, b); check(b == 8'h33, "R5", "read byte 1", b, 8'h33);
    mReadByte(1'b0, b); check(b == 8'h46, "R5", "read byte 2", b, 8'h46);
    mStop();
    check(regAddr == 4'h7, "R5", "pointer after read", regAddr, 7);
  endtask

  task automatic testWrap();
    bit a; logic [7:0] b;
    mStart(); mSendByte(8'hA2, a); mSendByte(8'h0E, a);
    mSendByte(8'hAA, a); mSendByte(8'hBB, a); mSendByte(8'hCC, a); mStop();
    check(mem[14] == 8'hAA, "R6", "mem[E]", mem[14], 8'hAA);
    check(mem[15] == 8'hBB, "R6", "mem[F]", mem[15], 8'hBB);
    check(mem[0] == 8'hCC, "R6", "mem[0] after wrap", mem[0], 8'hCC);
    check(regAddr == 4'h1, "R6", "pointer after write wrap", regAddr, 1);
    mStart(); mSendByte(8'hA2, a); mSendByte(8'hF2, a); mSendByte(8'h5A, a); mStop();
    check(mem[2] == 8'h5A, "R3", "upper nibble of word ignored", mem[2], 8'h5A);
    setPointer(8'h0F);
    mStart(); mSendByte(8'hA3, a);
    mReadByte(1'b1, b); check(b == 8'hBB, "R6", "read at F", b, 8'hBB);
    mReadByte(1'b0, b); check(b == 8'hCC, "R6", "read wraps to 0", b, 8'hCC);
    mStop();
  endtask

  task automatic testForeign();
    bit a; int w0 = writeCount; int l0 = lowCount; logic [3:0] p0 = regAddr;
    mStart();
    mSendByte(8'hA4, a); check(!a, "R2", "foreign address not acked", a, 0);
    mSendByte(8'h00, a); check(!a, "R2", "following byte not acked", a, 0);
    mStop();
    check(writeCount == w0, "R2", "no write after foreign address", writeCount - w0, 0);
    check(lowCount == l0, "R2", "line never pulled", lowCount - l0, 0);
    check(regAddr == p0, "R2", "pointer untouched", regAddr, p0);
  endtask

  task automatic testNack();
    bit a; logic [7:0] b; int l0;
    setPointer(8'h08);
    mStart(); mSendByte(8'hA3, a);
    mReadByte(1'b0, b); check(b == 8'h48, "R8", "byte before NACK", b, 8'h48);
    l0 = lowCount;
    mReadByte(1'b0, b);
    check(b == 8'hFF, "R8", "no data after NACK", b, 8'hFF);
    check(lowCount == l0, "R8", "line released after NACK", lowCount - l0, 0);
    mStop();
  endtask

  task automatic testAbort();
    bit a; logic [7:0] b; int w0;
    setPointer(8'h09);
    w0 = writeCount;
    mStart(); mSendByte(8'hA2, a); mSendByte(8'h09, a);
    mBit(1'b1); mBit(1'b0); mBit(1'b0); mBit(1'b1);
    mStop();
    check(writeCount == w0, "R9", "STOP mid-byte writes nothing", writeCount - w0, 0);
    mStart(); mSendByte(8'hA2, a); mSendByte(8'h09, a);
    mBit(1'b0); mBit(1'b1); mBit(1'b1);
    mStart();
    mSendByte(8'hA3, a); check(a, "R9", "START mid-byte opens new address", a, 1);
    mReadByte(1'b0, b); check(b == 8'h49, "R9", "partial byte not stored", b, 8'h49);
    mStop();
    check(writeCount == w0, "R9", "START mid-byte writes nothing", writeCount - w0, 0);
  endtask

  task automatic testBusReset();
    bit a; logic [7:0] b; int w0;
    setPointer(8'h05);
    check(regAddr == 4'h5, "R10", "pointer set before reset", regAddr, 5);
    w0 = writeCount;
    busRstN = 1'b0; repeat (4) @(negedge clk);
    check(regAddr == 4'h0, "R10", "pointer cleared by reset", regAddr, 0);
    check(sdaLow == 1'b0, "R10", "line released in reset", sdaLow, 0);
    busRstN = 1'b1; repeat (3) @(negedge clk);
    check(writeCount == w0, "R10", "no write from reset", writeCount - w0, 0);
    check(mem[5] == 8'h33, "R10", "core contents kept", mem[5], 8'h33);
    mStart(); mSendByte(8'hA3, a);
    mReadByte(1'b0, b); check(b == 8'hCC, "R10", "read from cleared pointer", b, 8'hCC);
    mStop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    memPreset = 1'b0;
    busRstN = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    testWriteBurst();
    testReadBurst();
    testWrap();
    testForeign();
    testNack();
    testAbort();
    testBusReset();
    check(sclHighChanges == 0, "R11", "line changed while SCL high", sclHighChanges, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog run did not finish actual=%0h expected=%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule